// File: doc/BRIEF.md
# Ternary Edge Gradient Histogram Builder

This block turns a raster-ordered pixel stream into per-cell histograms of edge orientation. Every pixel is compared with the pixel to its right and the pixel below it. Each of the two differences is reduced to a three-valued edge code, using a programmable dead-band threshold. The pair of codes then indexes a nine-entry table. The table returns an orientation bin and a small magnitude, so no angle or square-root arithmetic is needed. The magnitudes are summed per bin for each square cell of pixels.

Rows of pixels arrive one after another. The previous row is kept in a line buffer, so a pixel is evaluated when its lower neighbour arrives. The bottom row of the frame is swept from the line buffer once the frame has ended. When the last line of a cell row has been evaluated, the block stops accepting pixels. It then sends the histograms of that cell row, left to right, on a valid/ready stream and clears each accumulator as its histogram is taken.

Top module: `tegh_hist_top`

## Requirements
- R1: Each edge code is taken from d = neighbour − pixel. If d > thr_level the code is 01, if d < −thr_level the code is 10, and otherwise it is 00. The code 11 never occurs.
- R2: A difference with |d| equal to thr_level, or smaller, gives code 00 and adds nothing to any histogram.
- R3: With the default table, the pair (horizontal, vertical) maps as follows: (01,00) to bin 0 with magnitude 4, (01,01) to bin 1 with magnitude 6, (00,01) to bin 2 with magnitude 4, (10,01) to bin 3 with magnitude 6, (10,00) to bin 4 with magnitude 4, (10,10) to bin 5 with magnitude 6, (00,10) to bin 6 with magnitude 4, (01,10) to bin 7 with magnitude 6, and (00,00) to bin 8 with magnitude 0.
- R4: Edges of opposite polarity along the same axis land in different bins. A rising horizontal ramp fills bin 0, and a falling horizontal ramp fills bin 4.
- R5: A pixel in the last column has horizontal code 00, and a pixel in the last row has vertical code 00.
- R6: Each CELL×CELL cell (8×8 by default) has 9 bins, and each bin holds the sum of the magnitudes that fall in it. In out_hist, bin b occupies bits [b·ACC_W +: ACC_W].
- R7: A cell row is emitted once its last pixel line has been evaluated, with out_col running from 0 upward and out_row giving the cell row. The bottom cell row is emitted after the final pixel of the frame. Every accumulator starts from zero for the next cell row and for the next frame.
- R8: While out_valid is high and out_ready is low, out_valid, out_col, out_row and out_hist hold their values. in_ready is low during emission and during the bottom-row sweep.
- R9: Accumulators are wide enough for 64 pixels at magnitude 7 (9 bits by default). A cell of 64 diagonal pixels reports 384 without wrapping.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_level | input | PIX_W | Dead-band threshold for edge coding, held steady during a frame |
| pix_valid | input | 1 | A pixel is offered |
| pix_data | input | PIX_W | Pixel value, raster order |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| out_valid | output | 1 | A cell histogram is offered |
| out_ready | input | 1 | Consumer takes the histogram |
| out_col | output | C_W | Cell column of the histogram |
| out_row | output | R_W | Cell row of the histogram |
| out_hist | output | 9·ACC_W | Packed bin sums |

## Verification
The hardest situation to reach is the bottom cell row. No further pixel arrives to trigger its evaluation, so only the internal sweep after the last pixel can produce its histograms. The bench therefore compares every cell of every frame, including the bottom-right cell, where the right-column and bottom-row rules apply together. Frames run back to back with different patterns, so that stale accumulator contents would show up. On selected frames the consumer holds out_ready low while a histogram is offered, so the hold behaviour and the stalled input are observed while a cell row is waiting to drain.

// File: rtl/tegh_pkg.sv
package tegh_pkg;

    typedef enum logic [1:0] {
        TC_NONE = 2'b00,
        TC_POS  = 2'b01,
        TC_NEG  = 2'b10
    } tcode_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_FLUSH,
        ST_EMIT
    } state_e;

    localparam int NUM_BINS = 9;
    localparam int BIN_W    = 4;
    localparam int MAG_W    = 3;
    localparam int ENT_W    = BIN_W + MAG_W;
    localparam int ROM_N    = 9;
    localparam int MAG_MAX  = (1 << MAG_W) - 1;

    typedef struct packed {
        logic [BIN_W-1:0] bin;
        logic [MAG_W-1:0] mag;
    } lut_ent_t;

    function automatic int unsigned code_idx(tcode_e c);
        case (c)
            TC_POS:  return 1;
            TC_NEG:  return 2;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned pair_idx(tcode_e h, tcode_e v);
        return code_idx(h) * 3 + code_idx(v);
    endfunction

    function automatic lut_ent_t mk_ent(int unsigned b, int unsigned m);
        lut_ent_t e;
        e.bin = BIN_W'(b);
        e.mag = MAG_W'(m);
        return e;
    endfunction

    // Directions step by 45 degrees; bin k and bin k+4 are opposite polarity.
    function automatic logic [ROM_N*ENT_W-1:0] default_rom();
        logic [ROM_N*ENT_W-1:0] r;
        r = '0;
        r[0*ENT_W +: ENT_W] = mk_ent(8, 0);  // none,  none
        r[1*ENT_W +: ENT_W] = mk_ent(2, 4);  // none,  pos
        r[2*ENT_W +: ENT_W] = mk_ent(6, 4);  // none,  neg
        r[3*ENT_W +: ENT_W] = mk_ent(0, 4);  // pos,   none
        r[4*ENT_W +: ENT_W] = mk_ent(1, 6);  // pos,   pos
        r[5*ENT_W +: ENT_W] = mk_ent(7, 6);  // pos,   neg
        r[6*ENT_W +: ENT_W] = mk_ent(4, 4);  // neg,   none
        r[7*ENT_W +: ENT_W] = mk_ent(3, 6);  // neg,   pos
        r[8*ENT_W +: ENT_W] = mk_ent(5, 6);  // neg,   neg
        return r;
    endfunction

endpackage

// File: rtl/tegh_quant.sv
module tegh_quant
    import tegh_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] pix,
    input  logic [PIX_W-1:0] nbr,
    input  logic             nbr_ok,
    input  logic [PIX_W-1:0] thr,
    output tcode_e           code
);
    localparam int D_W = PIX_W + 1;

    logic signed [D_W-1:0] diff;
    logic signed [D_W-1:0] thr_s;

    always_comb begin
        diff  = $signed({1'b0, nbr}) - $signed({1'b0, pix});
        thr_s = $signed({1'b0, thr});
        code  = TC_NONE;
        if (nbr_ok) begin
            if (diff > thr_s) begin
                code = TC_POS;
            end else if (diff < -thr_s) begin
                code = TC_NEG;
            end
        end
    end

endmodule

// File: rtl/tegh_lut.sv
module tegh_lut
    import tegh_pkg::*;
#(
    parameter logic [ROM_N*ENT_W-1:0] ROM = default_rom()
) (
    input  tcode_e           hcode,
    input  tcode_e           vcode,
    output logic [BIN_W-1:0] bin,
    output logic [MAG_W-1:0] mag
);
    lut_ent_t ent;

    always_comb begin
        ent = ROM[pair_idx(hcode, vcode)*ENT_W +: ENT_W];
        bin = ent.bin;
        mag = ent.mag;
    end

endmodule

// File: rtl/tegh_linebuf.sv
module tegh_linebuf #(
    parameter int WIDTH = 256,
    parameter int PIX_W = 8,
    localparam int A_W  = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [A_W-1:0]   addr,
    input  logic [PIX_W-1:0] wr_data,
    output logic [PIX_W-1:0] rd_cur,
    output logic [PIX_W-1:0] rd_nxt
);
    logic [PIX_W-1:0] mem [WIDTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end

    always_comb begin
        rd_cur = mem[addr];
        if (addr == A_W'(WIDTH - 1)) begin
            rd_nxt = '0;
        end else begin
            rd_nxt = mem[addr + A_W'(1)];
        end
    end

endmodule

// File: rtl/tegh_accum.sv
module tegh_accum
    import tegh_pkg::*;
#(
    parameter int N_CELL = 32,
    parameter int ACC_W  = 9,
    localparam int C_W   = (N_CELL > 1) ? $clog2(N_CELL) : 1,
    localparam int HIST_W = NUM_BINS * ACC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              add_en,
    input  logic [C_W-1:0]    add_cell,
    input  logic [BIN_W-1:0]  add_bin,
    input  logic [MAG_W-1:0]  add_mag,
    input  logic              clr_en,
    input  logic [C_W-1:0]    clr_cell,
    input  logic [C_W-1:0]    rd_cell,
    output logic [HIST_W-1:0] rd_hist
);
    logic [ACC_W-1:0] acc_q [N_CELL][NUM_BINS];

    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
        for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
            always_ff @(posedge clk) begin
                if (rst) begin
                    acc_q[c][b] <= '0;
                end else if (clr_en && clr_cell == C_W'(c)) begin
                    acc_q[c][b] <= '0;
                end else if (add_en && add_cell == C_W'(c) && add_bin == BIN_W'(b)) begin
                    acc_q[c][b] <= acc_q[c][b] + ACC_W'(add_mag);
                end
            end
        end
    end

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_rd
        assign rd_hist[b*ACC_W +: ACC_W] = acc_q[rd_cell][b];
    end

    logic [ACC_W-1:0] sel_val;
    always_comb begin
        sel_val = '0;
        if (add_bin < BIN_W'(NUM_BINS)) begin
            sel_val = acc_q[add_cell][add_bin];
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        add_en |-> ({1'b0, sel_val} + (ACC_W+1)'(add_mag)) < (ACC_W+1)'(1 << ACC_W)); // R9

endmodule

// File: rtl/tegh_hist_top.sv
module tegh_hist_top
    import tegh_pkg::*;
#(
    parameter int IMG_W = 256,
    parameter int IMG_H = 256,
    parameter int CELL  = 8,
    parameter int PIX_W = 8,
    parameter logic [ROM_N*ENT_W-1:0] ROM = default_rom(),
    localparam int N_CELL  = IMG_W / CELL,
    localparam int N_CROW  = IMG_H / CELL,
    localparam int C_W     = (N_CELL > 1) ? $clog2(N_CELL) : 1,
    localparam int R_W     = (N_CROW > 1) ? $clog2(N_CROW) : 1,
    localparam int ACC_W   = $clog2(CELL * CELL * MAG_MAX + 1),
    localparam int HIST_W  = NUM_BINS * ACC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  thr_level,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [C_W-1:0]    out_col,
    output logic [R_W-1:0]    out_row,
    output logic [HIST_W-1:0] out_hist
);
    localparam int X_W      = $clog2(IMG_W);
    localparam int Y_W      = $clog2(IMG_H);
    localparam int CELL_SH  = $clog2(CELL);
    localparam logic [X_W-1:0] LAST_X = X_W'(IMG_W - 1);
    localparam logic [Y_W-1:0] LAST_Y = Y_W'(IMG_H - 1);
    localparam logic [C_W-1:0] LAST_C = C_W'(N_CELL - 1);

    state_e          state_q;
    logic [X_W-1:0]  in_x_q;
    logic [Y_W-1:0]  in_y_q;
    logic [X_W-1:0]  fl_x_q;
    logic [C_W-1:0]  em_idx_q;
    logic [R_W-1:0]  em_row_q;

    logic             accept;
    logic             ev_valid;
    logic [X_W-1:0]   ev_x;
    logic [Y_W-1:0]   ev_y;
    logic             low_ok;
    logic             right_ok;
    logic [PIX_W-1:0] low_pix;
    logic [PIX_W-1:0] cur_pix;
    logic [PIX_W-1:0] right_pix;
    logic             row_done;
    tcode_e           hcode;
    tcode_e           vcode;
    logic [BIN_W-1:0] lut_bin;
    logic [MAG_W-1:0] lut_mag;
    logic [C_W-1:0]   ev_cell;
    logic             clr_en;

    assign in_ready = (state_q == ST_RUN);
    assign accept   = pix_valid && in_ready;

    // Select which pixel is evaluated: the one above the arriving pixel,
    // or a bottom-row pixel during the sweep after the frame ends.
    always_comb begin
        ev_valid = 1'b0;
        ev_x     = in_x_q;
        ev_y     = in_y_q - Y_W'(1);
        low_ok   = 1'b1;
        low_pix  = pix_data;
        case (state_q)
            ST_RUN: begin
                ev_valid = accept && (in_y_q != '0);
            end
            ST_FLUSH: begin
                ev_valid = 1'b1;
                ev_x     = fl_x_q;
                ev_y     = LAST_Y;
                low_ok   = 1'b0;
                low_pix  = '0;
            end
            default: begin
                ev_valid = 1'b0;
            end
        endcase
    end

    assign right_ok = (ev_x != LAST_X);
    assign ev_cell  = C_W'(ev_x >> CELL_SH);
    assign row_done = ev_valid && (ev_x == LAST_X) && (&ev_y[CELL_SH-1:0]);
    assign clr_en   = (state_q == ST_EMIT) && out_ready;

    tegh_linebuf #(
        .WIDTH (IMG_W),
        .PIX_W (PIX_W)
    ) u_linebuf (
        .clk     (clk),
        .wr_en   (accept),
        .addr    (ev_x),
        .wr_data (pix_data),
        .rd_cur  (cur_pix),
        .rd_nxt  (right_pix)
    );

    tegh_quant #(.PIX_W(PIX_W)) u_quant_h (
        .pix    (cur_pix),
        .nbr    (right_pix),
        .nbr_ok (right_ok),
        .thr    (thr_level),
        .code   (hcode)
    );

    tegh_quant #(.PIX_W(PIX_W)) u_quant_v (
        .pix    (cur_pix),
        .nbr    (low_pix),
        .nbr_ok (low_ok),
        .thr    (thr_level),
        .code   (vcode)
    );

    tegh_lut #(.ROM(ROM)) u_lut (
        .hcode (hcode),
        .vcode (vcode),
        .bin   (lut_bin),
        .mag   (lut_mag)
    );

    tegh_accum #(
        .N_CELL (N_CELL),
        .ACC_W  (ACC_W)
    ) u_accum (
        .clk      (clk),
        .rst      (rst),
        .add_en   (ev_valid),
        .add_cell (ev_cell),
        .add_bin  (lut_bin),
        .add_mag  (lut_mag),
        .clr_en   (clr_en),
        .clr_cell (em_idx_q),
        .rd_cell  (em_idx_q),
        .rd_hist  (out_hist)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RUN;
            in_x_q   <= '0;
            in_y_q   <= '0;
            fl_x_q   <= '0;
            em_idx_q <= '0;
            em_row_q <= '0;
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (accept) begin
                        if (in_x_q == LAST_X) begin
                            in_x_q <= '0;
                            if (in_y_q == LAST_Y) begin
                                in_y_q  <= '0;
                                fl_x_q  <= '0;
                                state_q <= ST_FLUSH;
                            end else begin
                                in_y_q <= in_y_q + Y_W'(1);
                            end
                        end else begin
                            in_x_q <= in_x_q + X_W'(1);
                        end
                    end
                    if (row_done) begin
                        state_q  <= ST_EMIT;
                        em_idx_q <= '0;
                        em_row_q <= R_W'(ev_y >> CELL_SH);
                    end
                end
                ST_FLUSH: begin
                    fl_x_q <= fl_x_q + X_W'(1);
                    if (row_done) begin
                        state_q  <= ST_EMIT;
                        em_idx_q <= '0;
                        em_row_q <= R_W'(ev_y >> CELL_SH);
                    end
                end
                default: begin
                    if (out_ready) begin
                        if (em_idx_q == LAST_C) begin
                            state_q <= ST_RUN;
                        end else begin
                            em_idx_q <= em_idx_q + C_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    assign out_valid = (state_q == ST_EMIT);
    assign out_col   = em_idx_q;
    assign out_row   = em_row_q;

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> (hcode != 2'b11) && (vcode != 2'b11)); // R1

    AST_RIGHT_BORDER: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_x == LAST_X) |-> hcode == TC_NONE); // R5

    AST_BOTTOM_BORDER: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FLUSH) |-> vcode == TC_NONE); // R5

    AST_ZERO_PAIR: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && hcode == TC_NONE && vcode == TC_NONE) |-> lut_mag == '0); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_col)
                                      && $stable(out_row) && $stable(out_hist)); // R8

    AST_NO_ACCEPT_EMIT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R8

endmodule

// File: tb/tegh_hist_top_tb.sv
module tegh_hist_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TW    = 32;
    localparam int TH    = 16;
    localparam int TC    = 8;
    localparam int NCOL  = TW / TC;
    localparam int NROW  = TH / TC;
    localparam int ACC_W = 9;
    localparam int HW    = 9 * ACC_W;
    localparam int NSC   = 8;

    // Scenario table: pattern kind, threshold, backpressure, expected frame-wide sum (-1: model only)
    localparam int SC_KIND [NSC] = '{0, 1, 1, 2, 3, 4, 5, 5};
    localparam int SC_THR  [NSC] = '{0, 2, 4, 5, 0, 3, 10, 0};
    localparam int SC_BP   [NSC] = '{0, 0, 1, 0, 1, 0, 1, 0};
    localparam int SC_SUM  [NSC] = '{0, 1984, 0, 1984, 1920, 2974, -1, -1};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    thr_level = '0;
    logic          pix_valid = 1'b0;
    logic [7:0]    pix_data = '0;
    logic          in_ready;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [1:0]    out_col;
    logic [0:0]    out_row;
    logic [HW-1:0] out_hist;

    int n_chk  = 0;
    int n_fail = 0;

    int            exp_h [NROW][NCOL][9];
    logic [HW-1:0] got_h [NROW][NCOL];

    always #(CLK_PERIOD/2) clk = ~clk;

    tegh_hist_top #(
        .IMG_W (TW),
        .IMG_H (TH),
        .CELL  (TC),
        .PIX_W (8)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .thr_level (thr_level),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_col   (out_col),
        .out_row   (out_row),
        .out_hist  (out_hist)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    function automatic int pixv(int kind, int x, int y);
        case (kind)
            0: return 100;
            1: return 4 * x;
            2: return 255 - 6 * x;
            3: return 200 - 5 * y;
            4: return 4 * (x + y);
            default: return (x * 37 + y * 101 + x * y * 13) & 255;
        endcase
    endfunction

    function automatic int tern(int d, int t);
        if (d > t) return 1;
        if (d < -t) return 2;
        return 0;
    endfunction

    // Default table from R3: returns bin*16 + magnitude
    function automatic int lutv(int h, int v);
        case ({h[1:0], v[1:0]})
            4'b0100: return 0 * 16 + 4;
            4'b0101: return 1 * 16 + 6;
            4'b0001: return 2 * 16 + 4;
            4'b1001: return 3 * 16 + 6;
            4'b1000: return 4 * 16 + 4;
            4'b1010: return 5 * 16 + 6;
            4'b0010: return 6 * 16 + 4;
            4'b0110: return 7 * 16 + 6;
            default: return 8 * 16 + 0;
        endcase
    endfunction

    function automatic int binv(logic [HW-1:0] h, int b);
        return int'(h[b*ACC_W +: ACC_W]);
    endfunction

    task automatic build_model(input int kind, input int t);
        for (int r = 0; r < NROW; r++)
            for (int c = 0; c < NCOL; c++)
                for (int b = 0; b < 9; b++) exp_h[r][c][b] = 0;
        for (int y = 0; y < TH; y++) begin
            for (int x = 0; x < TW; x++) begin
                int h, v, e;
                h = (x < TW - 1) ? tern(pixv(kind, x + 1, y) - pixv(kind, x, y), t) : 0;
                v = (y < TH - 1) ? tern(pixv(kind, x, y + 1) - pixv(kind, x, y), t) : 0;
                e = lutv(h, v);
                exp_h[y / TC][x / TC][e / 16] += e % 16;
            end
        end
    endtask

    task automatic drive_frame(input int kind);
        for (int y = 0; y < TH; y++) begin
            for (int x = 0; x < TW; x++) begin
                while (!in_ready) @(negedge clk);
                pix_valid = 1'b1;
                pix_data  = 8'(pixv(kind, x, y));
                @(negedge clk);
            end
        end
        pix_valid = 1'b0;
    endtask

    task automatic collect(input int bp);
        int n;
        n = 0;
        while (n < NROW * NCOL) begin
            @(negedge clk);
            out_ready = 1'b0;
            if (out_valid) begin
                int r, c;
                logic [HW-1:0] expv;
                r = n / NCOL;
                c = n % NCOL;
                if (bp != 0) begin
                    logic [HW-1:0] snap;
                    int scol;
                    snap = out_hist;
                    scol = int'(out_col);
                    repeat (3) @(negedge clk);
                    chk(out_valid && out_hist == snap && int'(out_col) == scol,
                        "R8 hold", int'(out_col), scol);
                    chk(!in_ready, "R8 in_ready", int'(in_ready), 0);
                end
                chk(int'(out_row) == r && int'(out_col) == c, "R7 order",
                    int'(out_row) * 100 + int'(out_col), r * 100 + c);
                for (int b = 0; b < 9; b++) expv[b*ACC_W +: ACC_W] = ACC_W'(exp_h[r][c][b]);
                n_chk++;
                if (out_hist != expv) begin
                    n_fail++;
                    $display("FAIL R6 cell r%0d c%0d: actual %h expected %h", r, c, out_hist, expv);
                end
                got_h[r][c] = out_hist;
                out_ready = 1'b1;
                n++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);

        for (int s = 0; s < NSC; s++) begin
            int total;
            thr_level = 8'(SC_THR[s]);
            build_model(SC_KIND[s], SC_THR[s]);
            fork
                drive_frame(SC_KIND[s]);
                collect(SC_BP[s]);
            join
            total = 0;
            for (int r = 0; r < NROW; r++)
                for (int c = 0; c < NCOL; c++)
                    for (int b = 0; b < 9; b++) total += binv(got_h[r][c], b);
            if (SC_SUM[s] >= 0) chk(total == SC_SUM[s], "R6 R2 frame sum", total, SC_SUM[s]);

            case (s)
                1: begin
                    chk(binv(got_h[0][0], 0) == 256, "R3 ramp bin0", binv(got_h[0][0], 0), 256);
                    chk(binv(got_h[0][3], 0) == 224, "R5 right border", binv(got_h[0][3], 0), 224);
                    chk(binv(got_h[0][0], 4) == 0, "R4 no bin4", binv(got_h[0][0], 4), 0);
                end
                2: chk(binv(got_h[1][1], 0) == 0, "R2 equal threshold", binv(got_h[1][1], 0), 0);
                3: begin
                    chk(binv(got_h[0][0], 4) == 256, "R4 falling bin4", binv(got_h[0][0], 4), 256);
                    chk(binv(got_h[0][0], 0) == 0, "R4 falling bin0", binv(got_h[0][0], 0), 0);
                end
                4: chk(binv(got_h[1][0], 6) == 224, "R5 bottom border", binv(got_h[1][0], 6), 224);
                5: begin
                    chk(binv(got_h[0][0], 1) == 384, "R9 full cell", binv(got_h[0][0], 1), 384);
                    chk(binv(got_h[1][3], 1) == 294, "R3 corner diag", binv(got_h[1][3], 1), 294);
                    chk(binv(got_h[1][3], 2) == 28, "R5 corner right", binv(got_h[1][3], 2), 28);
                    chk(binv(got_h[1][3], 0) == 28, "R5 corner bottom", binv(got_h[1][3], 0), 28);
                    chk(binv(got_h[1][3], 8) == 0, "R1 R3 none bin", binv(got_h[1][3], 8), 0);
                end
                default: ;
            endcase
        end
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R7 idle after frame",
            int'(out_valid), 0);
        summary();
    end

endmodule